// File: doc/BRIEF.md
# Virtual-Channel Input Pipeline Controller

This block holds the per-channel control state for every input virtual channel of a wormhole router. Each channel is identified by its input port and its VC number, and each has its own small state machine. The machine watches the front flit of its buffer. When a head flit reaches an idle channel, the machine captures the packet's routing information. It then moves the packet through four steps: route lookup, output-VC allocation, switch allocation and crossbar traversal. On every flit it forwards, the block returns one credit upstream.

The flit storage, the two allocators and the link timing are outside the block. The controller only sees buffer occupancy and the fields of the front flit. It presents requests to the allocators and receives their grants. It checks downstream credit for the output VC it was given. It issues a pop/forward strobe together with the values to write into the outgoing flit.

Permission to cross the switch covers one flit only. After any flit that is not a tail, the channel drops back to its VC-allocated state and must request the switch again.

Top module: `vcip_ctrl`

## Requirements
- R1: While reset is applied, every channel is idle. No VC request, switch request or forward strobe is raised. `out_port` and `out_vc` hold the invalid code, which is all ones in each field.
- R2: An idle channel captures a packet when its buffer is non-empty and the front flit is a head. Flit type codes are 2'b01 head, 2'b11 single-flit packet, 2'b10 tail and 2'b00 body. On capture the channel latches destination, class and arrival time, and `rc_dest` shows the destination in the following cycle. A body flit at the front of an idle channel is ignored: no request is raised and `rc_dest` does not change.
- R3: One cycle after capture, the channel latches `rc_port` as its output port. It then raises `va_req`, with `va_cls` carrying the captured class.
- R4: When `va_gnt` is seen with `va_req`, the channel records `va_gnt_vc` on `out_vc`. If its buffer is non-empty at that moment, it raises `sa_req` in the very next cycle.
- R5: `sa_req` is raised only when the buffer holds a flit. A channel with an allocated VC and an empty buffer waits without requesting the switch.
- R6: After `sa_gnt`, a flit is forwarded (`flit_go`) only when the buffer is non-empty and `dn_credit[out_port*NVC+out_vc]` is 1. Until both hold, the channel keeps waiting.
- R7: After a head or body flit is forwarded, the channel keeps `out_vc` and needs a fresh `sa_gnt` before it forwards the next flit. Two forwards on the same channel are never in consecutive cycles.
- R8: Forwarding a tail or single-flit packet pulses `va_free` in that cycle. In the next cycle `out_port` and `out_vc` show the invalid code, and the channel is idle again, ready to capture the next head.
- R9: `credit_up` of a channel pulses in exactly the cycles in which that channel forwards a flit.
- R10: `flit_hops` equals the front flit's hop count plus one (modulo 2^HOP_W) for head and single-flit packets, and is unchanged for body and tail flits.
- R11: On the last flit, `flit_lat` equals the number of clock edges from the capturing edge to the forwarding edge, both counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| buf_occ | input | NIVC*OW | Buffer occupancy per input channel |
| hd_type | input | NIVC*2 | Front flit type per channel |
| hd_dest | input | NIVC*DEST_W | Front flit destination per channel |
| hd_cls | input | NIVC*CLS_W | Front flit message class per channel |
| hd_hops | input | NIVC*HOP_W | Front flit hop count per channel |
| rc_dest | output | NIVC*DEST_W | Captured destination, fed to the route lookup |
| rc_port | input | NIVC*PW | Output port returned by the route lookup |
| va_req | output | NIVC | Output-VC allocation request |
| va_cls | output | NIVC*CLS_W | Message class accompanying the VC request |
| va_gnt | input | NIVC | VC allocation grant |
| va_gnt_vc | input | NIVC*VW | Granted output VC |
| va_free | output | NIVC | Output VC released on the last flit |
| sa_req | output | NIVC | Switch allocation request |
| sa_gnt | input | NIVC | Switch allocation grant |
| dn_credit | input | NPORT*NVC | Credit available per output VC |
| out_port | output | NIVC*PW | Held output port, all ones when unset |
| out_vc | output | NIVC*VW | Held output VC, all ones when unset |
| flit_go | output | NIVC | Forward strobe (pops the buffer) |
| flit_hops | output | NIVC*HOP_W | Hop count to write into the forwarded flit |
| flit_lat | output | NIVC*TS_W | Packet latency, valid with the last flit |
| credit_up | output | NIVC | Credit returned upstream for this channel |

## Verification
The bound checker watches several rules on every cycle: that a granted output VC is recorded, that a switch request appears only with data in the buffer, that the same channel never forwards twice in a row, that the VC stays fixed across body flits, and that route fields are cleared after a tail. The other behaviours need scenarios, and only the bench can show them. These include the ordering chain in which a VC grant leads straight into a switch request, the wait for credit, and the pause in the allocated state while the buffer is empty. They also include the exact latency figure, the hop increment, and the rule that a stray body flit is ignored. Random traffic with bench-side allocators checks that every pushed flit leaves with the VC it was granted.

// File: rtl/vcip_pkg.sv
package vcip_pkg;

  typedef enum logic [2:0] {
    ST_EMPTY = 3'd0,
    ST_FULL  = 3'd1,
    ST_RC    = 3'd2,
    ST_VREQ  = 3'd3,
    ST_VDONE = 3'd4,
    ST_SREQ  = 3'd5,
    ST_XFER  = 3'd6
  } vc_state_e;

  // Front flit type encoding: bit 0 = carries header, bit 1 = ends packet
  localparam logic [1:0] FT_BODY = 2'b00;
  localparam logic [1:0] FT_HEAD = 2'b01;
  localparam logic [1:0] FT_TAIL = 2'b10;
  localparam logic [1:0] FT_SOLO = 2'b11;

endpackage

// File: rtl/vcip_rst_sync.sv
module vcip_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/vcip_tstamp.sv
module vcip_tstamp #(
  parameter int TS_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_en,
  output logic [TS_W-1:0] now
);

  logic [TS_W-1:0] cnt_q;
  logic [TS_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + TS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign now = cnt_q;

endmodule

// File: rtl/vcip_vc_slot.sv
module vcip_vc_slot
  import vcip_pkg::*;
#(
  parameter int NPORT  = 5,
  parameter int NVC    = 2,
  parameter int DEPTH  = 4,
  parameter int DEST_W = 4,
  parameter int CLS_W  = 2,
  parameter int HOP_W  = 4,
  parameter int TS_W   = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [TS_W-1:0]         now,
  input  logic [$clog2(DEPTH+1)-1:0] occ,
  input  logic [1:0]              ftype,
  input  logic [DEST_W-1:0]       fdest,
  input  logic [CLS_W-1:0]        fcls,
  input  logic [HOP_W-1:0]        fhops,
  input  logic [$clog2(NPORT+1)-1:0] rc_port,
  input  logic                    va_gnt,
  input  logic [$clog2(NVC+1)-1:0] va_gnt_vc,
  input  logic                    sa_gnt,
  input  logic [NPORT*NVC-1:0]    dn_credit,
  output logic [DEST_W-1:0]       rc_dest,
  output logic                    va_req,
  output logic [CLS_W-1:0]        va_cls,
  output logic                    va_free,
  output logic                    sa_req,
  output logic [$clog2(NPORT+1)-1:0] out_port,
  output logic [$clog2(NVC+1)-1:0] out_vc,
  output logic                    go,
  output logic [HOP_W-1:0]        go_hops,
  output logic [TS_W-1:0]         go_lat,
  output logic                    credit_up
);

  localparam int PW = $clog2(NPORT + 1);
  localparam int VW = $clog2(NVC + 1);
  localparam int OW = $clog2(DEPTH + 1);
  localparam int CW = PW + VW;
  localparam logic [PW-1:0] INV_P = {PW{1'b1}};
  localparam logic [VW-1:0] INV_V = {VW{1'b1}};

  vc_state_e         st_q, st_d;
  logic [PW-1:0]     op_q, op_d;
  logic [VW-1:0]     ovc_q, ovc_d;
  logic [CLS_W-1:0]  cls_q, cls_d;
  logic [DEST_W-1:0] dest_q, dest_d;
  logic [TS_W-1:0]   arr_q, arr_d;
  logic              upd_en;

  logic              has_flit;
  logic              more_left;
  logic              is_head;
  logic              is_last;
  logic [CW-1:0]     cidx;
  logic              route_ok;
  logic              cred_ok;

  // Front-of-buffer decode
  always_comb begin
    has_flit  = (occ != '0);
    more_left = (occ > OW'(1));
    is_head   = ftype[0];
    is_last   = ftype[1];
  end

  // Credit select for the held output VC
  always_comb begin
    cidx     = CW'(op_q) * CW'(NVC) + CW'(ovc_q);
    route_ok = (op_q < PW'(NPORT)) && (ovc_q < VW'(NVC));
    cred_ok  = route_ok && dn_credit[cidx];
  end

  always_comb begin
    go = (st_q == ST_XFER) && has_flit && cred_ok;
  end

  // Next state: stages resolved so that a grant can chain into the next request
  always_comb begin
    st_d   = st_q;
    op_d   = op_q;
    ovc_d  = ovc_q;
    cls_d  = cls_q;
    dest_d = dest_q;
    arr_d  = arr_q;
    case (st_q)
      ST_EMPTY, ST_FULL: begin
        if (has_flit && is_head) begin
          st_d   = ST_RC;
          dest_d = fdest;
          cls_d  = fcls;
          arr_d  = now;
        end
      end
      ST_RC: begin
        op_d = rc_port;
        st_d = ST_VREQ;
      end
      ST_VREQ: begin
        if (va_gnt) begin
          ovc_d = va_gnt_vc;
          st_d  = has_flit ? ST_SREQ : ST_VDONE;
        end
      end
      ST_VDONE: begin
        if (has_flit) begin
          st_d = ST_SREQ;
        end
      end
      ST_SREQ: begin
        if (sa_gnt) begin
          st_d = ST_XFER;
        end
      end
      ST_XFER: begin
        if (go) begin
          if (is_last) begin
            st_d  = more_left ? ST_FULL : ST_EMPTY;
            op_d  = INV_P;
            ovc_d = INV_V;
          end else begin
            st_d = more_left ? ST_SREQ : ST_VDONE;
          end
        end
      end
      default: begin
        st_d  = ST_EMPTY;
        op_d  = INV_P;
        ovc_d = INV_V;
      end
    endcase
  end

  always_comb begin
    upd_en = (st_d != st_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_EMPTY;
      op_q   <= INV_P;
      ovc_q  <= INV_V;
      cls_q  <= '0;
      dest_q <= '0;
      arr_q  <= '0;
    end else if (upd_en) begin
      st_q   <= st_d;
      op_q   <= op_d;
      ovc_q  <= ovc_d;
      cls_q  <= cls_d;
      dest_q <= dest_d;
      arr_q  <= arr_d;
    end
  end

  // Outputs
  always_comb begin
    rc_dest   = dest_q;
    va_req    = (st_q == ST_VREQ);
    va_cls    = cls_q;
    sa_req    = (st_q == ST_SREQ);
    out_port  = op_q;
    out_vc    = ovc_q;
    va_free   = go && is_last;
    credit_up = go;
    go_hops   = is_head ? (fhops + HOP_W'(1)) : fhops;
    go_lat    = now - arr_q + TS_W'(1);
  end

endmodule

// File: rtl/vcip_ctrl.sv
module vcip_ctrl
  import vcip_pkg::*;
#(
  parameter int NPORT  = 5,
  parameter int NVC    = 2,
  parameter int DEPTH  = 4,
  parameter int DEST_W = 4,
  parameter int CLS_W  = 2,
  parameter int HOP_W  = 4,
  parameter int TS_W   = 12,
  localparam int NIVC  = NPORT * NVC,
  localparam int PW    = $clog2(NPORT + 1),
  localparam int VW    = $clog2(NVC + 1),
  localparam int OW    = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NIVC*OW-1:0]     buf_occ,
  input  logic [NIVC*2-1:0]      hd_type,
  input  logic [NIVC*DEST_W-1:0] hd_dest,
  input  logic [NIVC*CLS_W-1:0]  hd_cls,
  input  logic [NIVC*HOP_W-1:0]  hd_hops,
  output logic [NIVC*DEST_W-1:0] rc_dest,
  input  logic [NIVC*PW-1:0]     rc_port,
  output logic [NIVC-1:0]        va_req,
  output logic [NIVC*CLS_W-1:0]  va_cls,
  input  logic [NIVC-1:0]        va_gnt,
  input  logic [NIVC*VW-1:0]     va_gnt_vc,
  output logic [NIVC-1:0]        va_free,
  output logic [NIVC-1:0]        sa_req,
  input  logic [NIVC-1:0]        sa_gnt,
  input  logic [NPORT*NVC-1:0]   dn_credit,
  output logic [NIVC*PW-1:0]     out_port,
  output logic [NIVC*VW-1:0]     out_vc,
  output logic [NIVC-1:0]        flit_go,
  output logic [NIVC*HOP_W-1:0]  flit_hops,
  output logic [NIVC*TS_W-1:0]   flit_lat,
  output logic [NIVC-1:0]        credit_up
);

  logic            rst_core_n;
  logic [TS_W-1:0] now;

  vcip_rst_sync #(
    .STAGES (2)
  ) u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_core_n)
  );

  vcip_tstamp #(
    .TS_W (TS_W)
  ) u_ts (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .tick_en (1'b1),
    .now     (now)
  );

  for (genvar g = 0; g < NIVC; g++) begin : g_slot
    vcip_vc_slot #(
      .NPORT  (NPORT),
      .NVC    (NVC),
      .DEPTH  (DEPTH),
      .DEST_W (DEST_W),
      .CLS_W  (CLS_W),
      .HOP_W  (HOP_W),
      .TS_W   (TS_W)
    ) u_slot (
      .clk       (clk),
      .rst_n     (rst_core_n),
      .now       (now),
      .occ       (buf_occ[g*OW +: OW]),
      .ftype     (hd_type[g*2 +: 2]),
      .fdest     (hd_dest[g*DEST_W +: DEST_W]),
      .fcls      (hd_cls[g*CLS_W +: CLS_W]),
      .fhops     (hd_hops[g*HOP_W +: HOP_W]),
      .rc_port   (rc_port[g*PW +: PW]),
      .va_gnt    (va_gnt[g]),
      .va_gnt_vc (va_gnt_vc[g*VW +: VW]),
      .sa_gnt    (sa_gnt[g]),
      .dn_credit (dn_credit),
      .rc_dest   (rc_dest[g*DEST_W +: DEST_W]),
      .va_req    (va_req[g]),
      .va_cls    (va_cls[g*CLS_W +: CLS_W]),
      .va_free   (va_free[g]),
      .sa_req    (sa_req[g]),
      .out_port  (out_port[g*PW +: PW]),
      .out_vc    (out_vc[g*VW +: VW]),
      .go        (flit_go[g]),
      .go_hops   (flit_hops[g*HOP_W +: HOP_W]),
      .go_lat    (flit_lat[g*TS_W +: TS_W]),
      .credit_up (credit_up[g])
    );
  end

endmodule

// File: rtl/vcip_ctrl_chk.sv
module vcip_ctrl_chk #(
  parameter int NPORT  = 5,
  parameter int NVC    = 2,
  parameter int DEPTH  = 4,
  localparam int NIVC  = NPORT * NVC,
  localparam int PW    = $clog2(NPORT + 1),
  localparam int VW    = $clog2(NVC + 1),
  localparam int OW    = $clog2(DEPTH + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NIVC*OW-1:0] buf_occ,
  input logic [NIVC*2-1:0]  hd_type,
  input logic [NIVC-1:0]    va_req,
  input logic [NIVC-1:0]    va_gnt,
  input logic [NIVC*VW-1:0] va_gnt_vc,
  input logic [NIVC-1:0]    sa_req,
  input logic [NIVC*PW-1:0] out_port,
  input logic [NIVC*VW-1:0] out_vc,
  input logic [NIVC-1:0]    flit_go
);

  for (genvar g = 0; g < NIVC; g++) begin : g_chk
    AST_GNT_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
      (va_req[g] && va_gnt[g]) |=> (out_vc[g*VW +: VW] == $past(va_gnt_vc[g*VW +: VW]))); // R4

    AST_SWREQ_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sa_req[g]) |-> (buf_occ[g*OW +: OW] != '0)); // R5

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
      flit_go[g] |=> !flit_go[g]); // R7

    AST_BODY_KEEPS_VC: assert property (@(posedge clk) disable iff (!rst_n)
      (flit_go[g] && !hd_type[g*2+1]) |=> $stable(out_vc[g*VW +: VW])); // R7

    AST_TAIL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (flit_go[g] && hd_type[g*2+1]) |=> ((out_port[g*PW +: PW] == {PW{1'b1}}) && (out_vc[g*VW +: VW] == {VW{1'b1}}))); // R8

    AST_REQ_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
      va_req[g] |-> (out_port[g*PW +: PW] != {PW{1'b1}})); // R3
  end

endmodule

bind vcip_ctrl vcip_ctrl_chk #(
  .NPORT (NPORT),
  .NVC   (NVC),
  .DEPTH (DEPTH)
) u_chk (.*);

// File: tb/vcip_ctrl_tb.sv
module vcip_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF   = CLK_PERIOD / 2;
  localparam int NPORT  = 5;
  localparam int NVC    = 2;
  localparam int DEPTH  = 4;
  localparam int DEST_W = 4;
  localparam int CLS_W  = 2;
  localparam int HOP_W  = 4;
  localparam int TS_W   = 12;
  localparam int NIVC   = NPORT * NVC;
  localparam int PW     = $clog2(NPORT + 1);
  localparam int VW     = $clog2(NVC + 1);
  localparam int OW     = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NIVC*OW-1:0]     buf_occ = '0;
  logic [NIVC*2-1:0]      hd_type = '0;
  logic [NIVC*DEST_W-1:0] hd_dest = '0;
  logic [NIVC*CLS_W-1:0]  hd_cls = '0;
  logic [NIVC*HOP_W-1:0]  hd_hops = '0;
  logic [NIVC*PW-1:0]     rc_port = '0;
  logic [NIVC-1:0]        va_gnt = '0;
  logic [NIVC*VW-1:0]     va_gnt_vc = '0;
  logic [NIVC-1:0]        sa_gnt = '0;
  logic [NPORT*NVC-1:0]   dn_credit = '0;
  logic [NIVC*DEST_W-1:0] rc_dest;
  logic [NIVC-1:0]        va_req;
  logic [NIVC*CLS_W-1:0]  va_cls;
  logic [NIVC-1:0]        va_free;
  logic [NIVC-1:0]        sa_req;
  logic [NIVC*PW-1:0]     out_port;
  logic [NIVC*VW-1:0]     out_vc;
  logic [NIVC-1:0]        flit_go;
  logic [NIVC*HOP_W-1:0]  flit_hops;
  logic [NIVC*TS_W-1:0]   flit_lat;
  logic [NIVC-1:0]        credit_up;

  always #(HALF) clk = ~clk;

  vcip_ctrl #(
    .NPORT(NPORT), .NVC(NVC), .DEPTH(DEPTH), .DEST_W(DEST_W),
    .CLS_W(CLS_W), .HOP_W(HOP_W), .TS_W(TS_W)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .buf_occ(buf_occ), .hd_type(hd_type),
    .hd_dest(hd_dest), .hd_cls(hd_cls), .hd_hops(hd_hops), .rc_dest(rc_dest),
    .rc_port(rc_port), .va_req(va_req), .va_cls(va_cls), .va_gnt(va_gnt),
    .va_gnt_vc(va_gnt_vc), .va_free(va_free), .sa_req(sa_req), .sa_gnt(sa_gnt),
    .dn_credit(dn_credit), .out_port(out_port), .out_vc(out_vc),
    .flit_go(flit_go), .flit_hops(flit_hops), .flit_lat(flit_lat),
    .credit_up(credit_up)
  );

  // Bench model
  int qt[NIVC][$];
  int qd[NIVC][$];
  int qc[NIVC][$];
  int qh[NIVC][$];
  int rem[NIVC];
  int pdst[NIVC];
  int pcls[NIVC];
  int gp[NIVC];
  int gvc[NIVC];
  bit got_gnt[NIVC];
  bit pend_clr[NIVC];
  bit busy[NPORT*NVC];
  int n_chk = 0;
  int n_bad = 0;
  int n_push = 0;
  int n_pop = 0;
  int cred_mode = 1;
  bit rnd = 1'b0;
  bit push_on = 1'b0;
  bit new_ok = 1'b0;
  bit done = 1'b0;

  function automatic int route(int d);
    return d % NPORT;
  endfunction

  function automatic int exp_hops(int t, int h);
    return ((t & 1) != 0) ? ((h + 1) % (1 << HOP_W)) : h;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push(int i, int t, int d, int c, int h);
    qt[i].push_back(t);
    qd[i].push_back(d);
    qc[i].push_back(c);
    qh[i].push_back(h);
    n_push++;
  endtask

  task automatic gen_push(int i);
    if (rem[i] == 0) begin
      if (!new_ok) return;
      rem[i] = 1 + int'($urandom % 3);
      pdst[i] = int'($urandom % 16);
      pcls[i] = int'($urandom % 4);
      push(i, (rem[i] == 1) ? 3 : 1, pdst[i], pcls[i], int'($urandom % 15));
    end else begin
      push(i, (rem[i] == 1) ? 2 : 0, pdst[i], pcls[i], int'($urandom % 15));
    end
    rem[i]--;
  endtask

  task automatic clear_model();
    for (int i = 0; i < NIVC; i++) begin
      qt[i].delete(); qd[i].delete(); qc[i].delete(); qh[i].delete();
      rem[i] = 0; got_gnt[i] = 1'b0; pend_clr[i] = 1'b0; gp[i] = 0; gvc[i] = 0;
    end
    for (int k = 0; k < NPORT*NVC; k++) busy[k] = 1'b0;
    n_push = 0;
    n_pop = 0;
  endtask

  task automatic drive();
    bit port_has[NPORT];
    bit va_done[NPORT];
    if (push_on) begin
      for (int i = 0; i < NIVC; i++)
        if (qt[i].size() < DEPTH && ($urandom % 3) == 0) gen_push(i);
    end
    for (int i = 0; i < NIVC; i++) begin
      buf_occ[i*OW +: OW] = OW'(qt[i].size());
      if (qt[i].size() > 0) begin
        hd_type[i*2 +: 2]          = 2'(qt[i][0]);
        hd_dest[i*DEST_W +: DEST_W] = DEST_W'(qd[i][0]);
        hd_cls[i*CLS_W +: CLS_W]    = CLS_W'(qc[i][0]);
        hd_hops[i*HOP_W +: HOP_W]   = HOP_W'(qh[i][0]);
      end else begin
        hd_type[i*2 +: 2]          = '0;
        hd_dest[i*DEST_W +: DEST_W] = '0;
        hd_cls[i*CLS_W +: CLS_W]    = '0;
        hd_hops[i*HOP_W +: HOP_W]   = '0;
      end
      rc_port[i*PW +: PW] = PW'(route(int'(rc_dest[i*DEST_W +: DEST_W])));
    end
    va_gnt = '0;
    va_gnt_vc = '0;
    sa_gnt = '0;
    for (int p = 0; p < NPORT; p++) begin
      port_has[p] = 1'b0;
      va_done[p] = 1'b0;
    end
    for (int i = 0; i < NIVC; i++)
      if (got_gnt[i]) port_has[gp[i]] = 1'b1;
    for (int i = 0; i < NIVC; i++) begin
      if (va_req[i] && qt[i].size() > 0 && (!rnd || ($urandom % 4) != 0)) begin
        int p;
        p = route(qd[i][0]);
        if (!va_done[p]) begin
          for (int v = 0; v < NVC; v++) begin
            if (!va_gnt[i] && !busy[p*NVC+v]) begin
              va_gnt[i] = 1'b1;
              va_gnt_vc[i*VW +: VW] = VW'(v);
              busy[p*NVC+v] = 1'b1;
              gp[i] = p;
              gvc[i] = v;
              va_done[p] = 1'b1;
            end
          end
        end
      end
      if (sa_req[i] && !port_has[gp[i]] && (!rnd || ($urandom % 4) != 0)) begin
        sa_gnt[i] = 1'b1;
        got_gnt[i] = 1'b1;
        port_has[gp[i]] = 1'b1;
      end
    end
    for (int k = 0; k < NPORT*NVC; k++)
      dn_credit[k] = (cred_mode == 1) ? 1'b1 : (cred_mode == 0) ? 1'b0 : (($urandom % 3) != 0);
  endtask

  task automatic sample();
    chk(credit_up === flit_go, "R9", credit_up, flit_go);
    chk((va_free & ~flit_go) == '0, "R8", va_free, 0);
    for (int i = 0; i < NIVC; i++) begin
      if (pend_clr[i]) begin
        chk(out_port[i*PW +: PW] == {PW{1'b1}} && out_vc[i*VW +: VW] == {VW{1'b1}},
            "R8", out_port[i*PW +: PW], {PW{1'b1}});
        pend_clr[i] = 1'b0;
      end
      if (va_req[i] && qt[i].size() > 0)
        chk(int'(out_port[i*PW +: PW]) == route(qd[i][0]), "R3", out_port[i*PW +: PW], route(qd[i][0]));
      if (sa_req[i]) chk(qt[i].size() > 0, "R5", qt[i].size(), 1);
      if (flit_go[i]) begin
        chk(qt[i].size() > 0, "R6", qt[i].size(), 1);
        chk(got_gnt[i], "R7", got_gnt[i], 1);
        chk(dn_credit[gp[i]*NVC + gvc[i]] == 1'b1, "R6", dn_credit[gp[i]*NVC + gvc[i]], 1);
        chk(int'(out_vc[i*VW +: VW]) == gvc[i], "R4", out_vc[i*VW +: VW], gvc[i]);
        if (qt[i].size() > 0) begin
          int t, h;
          t = qt[i][0];
          h = qh[i][0];
          chk(int'(flit_hops[i*HOP_W +: HOP_W]) == exp_hops(t, h), "R10",
              flit_hops[i*HOP_W +: HOP_W], exp_hops(t, h));
          chk(va_free[i] == ((t & 2) != 0), "R8", va_free[i], (t & 2) != 0);
          if ((t & 2) != 0) begin
            busy[gp[i]*NVC + gvc[i]] = 1'b0;
            pend_clr[i] = 1'b1;
          end
          void'(qt[i].pop_front()); void'(qd[i].pop_front());
          void'(qc[i].pop_front()); void'(qh[i].pop_front());
          n_pop++;
        end
        got_gnt[i] = 1'b0;
      end
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    drive();
    #(HALF - 1);
    sample();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    clear_model();
    repeat (3) cycle();
    chk(va_req == '0 && sa_req == '0 && flit_go == '0, "R1", {va_req, sa_req, flit_go}, 0);
    chk(out_port == {(NIVC*PW){1'b1}} && out_vc == {(NIVC*VW){1'b1}}, "R1", out_port, {(NIVC*PW){1'b1}});
    rst_n = 1'b1;
    repeat (3) cycle();
  endtask

  initial begin
    void'($urandom(32'h1d5eed));
    rnd = 1'b0;
    push_on = 1'b0;
    cred_mode = 1;
    do_reset();

    // Directed: single-flit packet with immediate grants, dest 7 -> port 2
    push(0, 3, 7, 2, 5);
    cycle(); chk(va_req[0] == 1'b0, "R2", va_req[0], 0);
    cycle(); chk(rc_dest[0 +: DEST_W] == DEST_W'(7), "R2", rc_dest[0 +: DEST_W], 7);
    cycle(); chk(va_req[0] && out_port[0 +: PW] == PW'(2) && va_cls[0 +: CLS_W] == CLS_W'(2),
                 "R3", out_port[0 +: PW], 2);
    cycle(); chk(sa_req[0] == 1'b1, "R4", sa_req[0], 1);
             chk(out_vc[0 +: VW] == VW'(0), "R4", out_vc[0 +: VW], 0);
    cycle(); chk(flit_go[0] == 1'b1, "R6", flit_go[0], 1);
             chk(flit_lat[0 +: TS_W] == TS_W'(5), "R11", flit_lat[0 +: TS_W], 5);
             chk(va_free[0] == 1'b1, "R8", va_free[0], 1);
    cycle(); chk(out_port[0 +: PW] == {PW{1'b1}}, "R8", out_port[0 +: PW], {PW{1'b1}});

    // Directed: two-flit packet, credit withheld, tail arrives late
    cred_mode = 0;
    push(0, 1, 3, 1, 9);
    repeat (4) cycle();
    chk(sa_req[0] == 1'b1, "R4", sa_req[0], 1);
    cycle(); chk(flit_go[0] == 1'b0, "R6", flit_go[0], 0);
    cred_mode = 1;
    cycle(); chk(flit_go[0] == 1'b1, "R6", flit_go[0], 1);
             chk(flit_hops[0 +: HOP_W] == HOP_W'(10), "R10", flit_hops[0 +: HOP_W], 10);
             chk(va_free[0] == 1'b0, "R8", va_free[0], 0);
    cycle(); chk(sa_req[0] == 1'b0, "R5", sa_req[0], 0);
             chk(out_vc[0 +: VW] == VW'(0), "R7", out_vc[0 +: VW], 0);
    cycle(); chk(sa_req[0] == 1'b0, "R5", sa_req[0], 0);
    push(0, 2, 3, 1, 4);
    cycle(); chk(sa_req[0] == 1'b0, "R5", sa_req[0], 0);
    cycle(); chk(sa_req[0] == 1'b1, "R5", sa_req[0], 1);
    cycle(); chk(flit_go[0] == 1'b1, "R7", flit_go[0], 1);
             chk(flit_hops[0 +: HOP_W] == HOP_W'(4), "R10", flit_hops[0 +: HOP_W], 4);
             chk(va_free[0] == 1'b1, "R8", va_free[0], 1);
    cycle(); chk(out_port[0 +: PW] == {PW{1'b1}}, "R8", out_port[0 +: PW], {PW{1'b1}});

    // Directed: body flit at an idle channel is ignored
    do_reset();
    push(1, 0, 9, 1, 2);
    for (int k = 0; k < 4; k++) begin
      cycle();
      chk(va_req[1] == 1'b0 && rc_dest[DEST_W +: DEST_W] == '0, "R2", rc_dest[DEST_W +: DEST_W], 0);
    end
    do_reset();

    // Random traffic
    rnd = 1'b1;
    cred_mode = 2;
    push_on = 1'b1;
    new_ok = 1'b1;
    repeat (3000) cycle();
    new_ok = 1'b0;
    rnd = 1'b0;
    cred_mode = 1;
    repeat (600) cycle();
    chk(n_push == n_pop, "R6", n_pop, n_push);
    for (int i = 0; i < NIVC; i++) chk(qt[i].size() == 0, "R8", qt[i].size(), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule